// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave-only two-wire serial endpoint that holds a small set of board configuration values. A fast system clock oversamples the serial clock and data lines. The block finds bus START and STOP events, matches the address byte against one of two addresses picked by a strap pin, shifts bits in and out, and drives the acknowledge. It owns two writable configuration registers and one read-only register that holds a snapshot of a 5-bit parallel input port.

Each configuration register has a 6-bit data field in bits 5:0. Bits 7:6 of both registers show one shared 2-bit selector, which a downstream output multiplexer consumes. A write carries a single data byte. The top two bits of that byte pick the target register and also become the new selector. A read streams all three registers in a fixed order. A write-protect pin and a busy timer stand in for the slow non-volatile update. Committed contents change only when that timer expires.

Top module: `cfgport_i2c`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. The slave releases SDA (sda_oe=0) after either event.
- R2: The slave acknowledges its 7-bit address, which is 1001110 when addr_sel=1 and 0110111 when addr_sel=0. Any other address gets no acknowledge.
- R3: The general call address 0000000 is never acknowledged.
- R4: A read (R/W bit 1) returns register A, then register B, then the snapshot register, as long as the master acknowledges each byte.
- R5: A master NACK ends the read, and SDA is released until the next START. Reads never change register contents.
- R6: The snapshot register captures port_in on the first SCL rising edge after a START. Its bits 7:5 always read 000.
- R7: A write is the address byte with R/W bit 0, followed by one data byte. Data bits 7:6 become the shared selector. When they are 00, bits 5:0 go to register A. When they are 01, bits 5:0 go to register B. When they are 10 or 11, only the selector changes.
- R8: Bits 7:6 of register A and register B always read the same shared selector.
- R9: With wp=1, a write is still acknowledged but changes nothing, and busy stays low.
- R10: An accepted write raises busy for exactly BUSY_CYCLES clocks. The written value appears on reg_a/reg_b when busy falls. A write that arrives while busy is acknowledged and ignored.
- R11: A second data byte in the same write is not acknowledged and has no effect.
- R12: After reset both registers read 8'h80 (selector 10, data 0), busy is 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain enable) |
| addr_sel | input | 1 | Strap choosing which slave address applies |
| wp | input | 1 | Write protect; 1 blocks register updates |
| port_in | input | PORT_W | Parallel input port sampled into the snapshot |
| reg_a | output | 8 | Committed register A {selector, data} |
| reg_b | output | 8 | Committed register B {selector, data} |
| busy | output | 1 | Non-volatile update in progress |

## Verification
The checker watches every cycle and confirms four properties. SDA is released after each START and STOP. A protected write never starts the busy timer. Busy rises only after an unprotected write strobe and stays high for exactly BUSY_CYCLES clocks. The committed registers change only on the cycle busy falls, which covers reads leaving state untouched. The directed scenarios are what show the rest: address matching under both strap settings, refusal of the general call, the order of the read stream, the snapshot timing relative to later port changes, target decoding by the top data bits, and the NACK on an extra write byte.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } link_st_e;

    localparam logic [6:0] ADDR_STRAP_HI = 7'b1001110;
    localparam logic [6:0] ADDR_STRAP_LO = 7'b0110111;

    localparam logic [1:0] SEL_REG_A = 2'b00;
    localparam logic [1:0] SEL_REG_B = 2'b01;
    localparam logic [1:0] SEL_RESET = 2'b10;

    localparam int DATA_W = 6;

endpackage

// File: rtl/cfgport_lineconv.sv
module cfgport_lineconv #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_prev;
        logic                   sda_prev;
    } line_t;

    line_t q, d;

    always_comb begin
        d          = q;
        d.scl_sh   = {q.scl_sh[SYNC_STAGES-2:0], scl_i};
        d.sda_sh   = {q.sda_sh[SYNC_STAGES-2:0], sda_i};
        d.scl_prev = q.scl_sh[SYNC_STAGES-1];
        d.sda_prev = q.sda_sh[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s     = q.scl_sh[SYNC_STAGES-1];
    assign sda_s     = q.sda_sh[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~q.scl_prev;
    assign scl_fall  = ~scl_s & q.scl_prev;
    assign start_det = scl_s & q.scl_prev & q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & q.scl_prev & ~q.sda_prev & sda_s;

endmodule

// File: rtl/cfgport_link.sv
module cfgport_link
    import cfgport_pkg::*;
#(
    parameter int PORT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_sel,
    input  logic [PORT_W-1:0] port_in,
    input  logic [7:0]        reg_a,
    input  logic [7:0]        reg_b,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [7:0]        wr_byte
);

    localparam int PAD_W = 8 - PORT_W;

    typedef struct packed {
        link_st_e          st;
        logic [3:0]        cnt;
        logic [7:0]        shreg;
        logic              rw;
        logic [1:0]        idx;
        logic [PORT_W-1:0] snap;
        logic              snap_arm;
        logic              oe;
        logic              mack;
        logic              wstb;
    } link_t;

    link_t q, d;

    logic [6:0] own_addr;
    logic [7:0] snap_byte;
    logic [7:0] next_tx;

    assign own_addr  = addr_sel ? ADDR_STRAP_HI : ADDR_STRAP_LO;
    assign snap_byte = {{PAD_W{1'b0}}, q.snap};
    assign next_tx   = (q.idx == 2'd0) ? reg_b : snap_byte;

    always_comb begin
        d      = q;
        d.wstb = 1'b0;

        if (scl_rise && q.snap_arm) begin
            d.snap     = port_in;
            d.snap_arm = 1'b0;
        end

        if (start_det) begin
            d.st       = ST_ADDR;
            d.cnt      = 4'd0;
            d.oe       = 1'b0;
            d.snap_arm = 1'b1;
        end else if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise && q.cnt != 4'd8) begin
                        d.shreg = {q.shreg[6:0], sda_s};
                        d.cnt   = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        if (q.st == ST_ADDR) begin
                            if (q.shreg[7:1] == own_addr) begin
                                d.oe = 1'b1;
                                d.rw = q.shreg[0];
                                d.st = ST_ADDR_ACK;
                            end else begin
                                d.st = ST_SKIP;
                            end
                        end else begin
                            d.oe   = 1'b1;
                            d.wstb = 1'b1;
                            d.st   = ST_WACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.cnt = 4'd0;
                        if (q.rw) begin
                            d.idx   = 2'd0;
                            d.shreg = reg_a;
                            d.oe    = ~reg_a[7];
                            d.st    = ST_RDATA;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_WDATA;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        d.oe = 1'b0;
                        d.st = ST_SKIP;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            d.oe   = 1'b0;
                            d.mack = 1'b0;
                            d.st   = ST_RACK;
                        end else begin
                            d.shreg = {q.shreg[6:0], 1'b0};
                            d.oe    = ~q.shreg[6];
                            d.cnt   = q.cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack && q.idx != 2'd2) begin
                            d.idx   = q.idx + 2'd1;
                            d.shreg = next_tx;
                            d.oe    = ~next_tx[7];
                            d.cnt   = 4'd0;
                            d.st    = ST_RDATA;
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign sda_oe  = q.oe;
    assign wr_stb  = q.wstb;
    assign wr_byte = q.shreg;

endmodule

// File: rtl/cfgport_regs.sv
module cfgport_regs
    import cfgport_pkg::*;
#(
    parameter int BUSY_CYCLES = 1000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic [7:0] wr_byte,
    input  logic       wp,
    output logic [7:0] reg_a,
    output logic [7:0] reg_b,
    output logic       busy
);

    localparam int            CW       = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(BUSY_CYCLES - 1);

    typedef struct packed {
        logic [1:0]        sel;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [7:0]        pend;
        logic              busy;
        logic [CW-1:0]     cnt;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (q.busy) begin
            if (q.cnt == CNT_LAST) begin
                d.busy = 1'b0;
                d.cnt  = '0;
                d.sel  = q.pend[7:6];
                if (q.pend[7:6] == SEL_REG_A)      d.a = q.pend[DATA_W-1:0];
                else if (q.pend[7:6] == SEL_REG_B) d.b = q.pend[DATA_W-1:0];
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else if (wr_stb && !wp) begin
            d.pend = wr_byte;
            d.busy = 1'b1;
            d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sel: SEL_RESET, default: '0};
        else        q <= d;
    end

    assign reg_a = {q.sel, q.a};
    assign reg_b = {q.sel, q.b};
    assign busy  = q.busy;

endmodule

// File: rtl/cfgport_i2c.sv
module cfgport_i2c #(
    parameter int PORT_W      = 5,
    parameter int BUSY_CYCLES = 1000000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              addr_sel,
    input  logic              wp,
    input  logic [PORT_W-1:0] port_in,
    output logic [7:0]        reg_a,
    output logic [7:0]        reg_b,
    output logic              busy
);

    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_stb;
    logic [7:0] wr_byte;

    cfgport_lineconv #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfgport_link #(.PORT_W(PORT_W)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_sel  (addr_sel),
        .port_in   (port_in),
        .reg_a     (reg_a),
        .reg_b     (reg_b),
        .sda_oe    (sda_oe),
        .wr_stb    (wr_stb),
        .wr_byte   (wr_byte)
    );

    cfgport_regs #(.BUSY_CYCLES(BUSY_CYCLES)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_byte (wr_byte),
        .wp      (wp),
        .reg_a   (reg_a),
        .reg_b   (reg_b),
        .busy    (busy)
    );

    logic unused_scl;
    assign unused_scl = scl_s;

endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk #(
    parameter int BUSY_CYCLES = 1000000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_oe,
    input logic       wr_stb,
    input logic       wp,
    input logic       busy,
    input logic [7:0] reg_a,
    input logic [7:0] reg_b
);

    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    assert_release_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    assert_release_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    assert_protect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wp && !busy) |=> !busy);

    assert_busy_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(wr_stb) && !$past(wp)));

    assert_busy_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == BUSY_CYCLES));

    // R5: reads leave contents alone; only a timer expiry commits
    assert_regs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> ($stable(reg_a) && $stable(reg_b)));

endmodule

bind cfgport_i2c cfgport_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .wr_stb    (wr_stb),
    .wp        (wp),
    .busy      (busy),
    .reg_a     (reg_a),
    .reg_b     (reg_b)
);

// File: tb/cfgport_i2c_tb.sv
module cfgport_i2c_tb;

    localparam int Q    = 8;
    localparam int BUSY = 2000;
    localparam logic [6:0] A_HI = 7'b1001110;
    localparam logic [6:0] A_LO = 7'b0110111;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_low = 1'b0;
    logic       addr_sel = 1'b1;
    logic       wp = 1'b0;
    logic [4:0] port_in = 5'h00;
    logic       sda_oe, busy;
    logic [7:0] reg_a, reg_b;
    logic       sda_bus;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign sda_bus = ~(m_low | sda_oe);

    cfgport_i2c #(.PORT_W(5), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .addr_sel (addr_sel),
        .wp       (wp),
        .port_in  (port_in),
        .reg_a    (reg_a),
        .reg_b    (reg_b),
        .busy     (busy)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    task automatic bus_start();
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b1; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b0; tick(Q);
    endtask

    task automatic bit_out(input logic b);
        m_low = ~b; tick(Q);
        m_scl = 1'b1; tick(2 * Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bit_in(output logic b);
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        b = sda_bus; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            bit_in(s);
            b = {b[6:0], s};
        end
        bit_out(~give_ack);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] v,
                            output logic ack_a, output logic ack_d);
        bus_start();
        send_byte({a, 1'b0}, ack_a);
        send_byte(v, ack_d);
        bus_stop();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3 * BUSY && busy; i++) tick(1);
    endtask

    task automatic t_reset();
        check("R12 reg_a", reg_a, 8'h80);
        check("R12 reg_b", reg_b, 8'h80);
        check("R12 busy", busy, 1'b0);
        check("R12 sda_oe", sda_oe, 1'b0);
    endtask

    task automatic t_read_order();
        logic ack;
        logic [7:0] b0, b1, b2;
        addr_sel = 1'b1;
        port_in  = 5'h15;
        bus_start();
        send_byte({A_HI, 1'b1}, ack);
        port_in = 5'h0A;
        recv_byte(1'b1, b0);
        recv_byte(1'b1, b1);
        recv_byte(1'b0, b2);
        bus_stop();
        check("R2 ack hi strap", ack, 1'b1);
        check("R4 first byte A", b0, 8'h80);
        check("R4 second byte B", b1, 8'h80);
        check("R6 snapshot at first SCL edge", b2, 8'h15);
        check("R8 selector same", b0[7:6], b1[7:6]);
        check("R1 released after stop", sda_oe, 1'b0);
    endtask

    task automatic t_address();
        logic ack;
        addr_sel = 1'b1;
        bus_start(); send_byte({A_LO, 1'b1}, ack); bus_stop();
        check("R2 other address nack", ack, 1'b0);
        bus_start(); send_byte(8'h00, ack); bus_stop();
        check("R3 general call nack", ack, 1'b0);
        addr_sel = 1'b0;
        bus_start(); send_byte({A_HI, 1'b0}, ack); bus_stop();
        check("R2 hi addr with lo strap nack", ack, 1'b0);
        bus_start(); send_byte({A_LO, 1'b0}, ack); bus_stop();
        check("R2 ack lo strap", ack, 1'b1);
        check("R1 released after stop", sda_oe, 1'b0);
    endtask

    task automatic t_write_a();
        logic aa, ad, ack;
        logic [7:0] b0, b1, b2;
        addr_sel = 1'b0;
        do_write(A_LO, 8'h2A, aa, ad);
        check("R7 addr ack", aa, 1'b1);
        check("R7 data ack", ad, 1'b1);
        check("R10 busy after write", busy, 1'b1);
        check("R10 reg_a held while busy", reg_a, 8'h80);
        wait_idle();
        check("R7 reg_a written", reg_a, 8'h2A);
        check("R8 reg_b selector follows", reg_b, 8'h00);
        bus_start();
        send_byte({A_LO, 1'b1}, ack);
        recv_byte(1'b1, b0);
        recv_byte(1'b1, b1);
        recv_byte(1'b0, b2);
        bus_stop();
        check("R4 readback A", b0, 8'h2A);
        check("R8 readback B selector", b1, 8'h00);
        check("R6 snapshot upper zero", b2[7:5], 3'b000);
    endtask

    task automatic t_write_b();
        logic aa, ad;
        do_write(A_LO, 8'h55, aa, ad);
        wait_idle();
        check("R7 reg_b written", reg_b, 8'h55);
        check("R8 reg_a selector follows", reg_a, 8'h6A);
    endtask

    task automatic t_busy_ignore();
        logic aa, ad, aa2, ad2;
        do_write(A_LO, 8'h3F, aa, ad);
        do_write(A_LO, 8'h01, aa2, ad2);
        check("R10 busy write acked", ad2, 1'b1);
        check("R10 still busy", busy, 1'b1);
        wait_idle();
        check("R10 second write ignored", reg_a, 8'h3F);
        check("R10 reg_b", reg_b, 8'h15);
    endtask

    task automatic t_wp();
        logic aa, ad;
        wp = 1'b1;
        do_write(A_LO, 8'h11, aa, ad);
        check("R9 protected write acked", ad, 1'b1);
        tick(4);
        check("R9 busy stays low", busy, 1'b0);
        check("R9 reg_a unchanged", reg_a, 8'h3F);
        wp = 1'b0;
    endtask

    task automatic t_select_only();
        logic aa, ad;
        do_write(A_LO, 8'h80, aa, ad);
        wait_idle();
        check("R7 selector only reg_a", reg_a, 8'hBF);
        check("R7 selector only reg_b", reg_b, 8'h95);
    endtask

    task automatic t_extra_byte();
        logic ack, ack2;
        bus_start();
        send_byte({A_LO, 1'b0}, ack);
        send_byte(8'h05, ack);
        send_byte(8'h07, ack2);
        bus_stop();
        check("R11 first data acked", ack, 1'b1);
        check("R11 extra byte nack", ack2, 1'b0);
        wait_idle();
        check("R11 extra byte no effect", reg_a, 8'h05);
    endtask

    task automatic t_early_nack();
        logic ack;
        logic [7:0] b0;
        bus_start();
        send_byte({A_LO, 1'b1}, ack);
        recv_byte(1'b0, b0);
        check("R5 first byte", b0, 8'h05);
        tick(Q);
        check("R5 released after nack", sda_oe, 1'b0);
        bus_stop();
        check("R5 reg_a unchanged by read", reg_a, 8'h05);
        check("R5 reg_b unchanged by read", reg_b, 8'h15);
        check("R5 no busy from read", busy, 1'b0);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_read_order();
        t_address();
        t_write_a();
        t_write_b();
        t_busy_ignore();
        t_wp();
        t_select_only();
        t_extra_byte();
        t_early_nack();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

endmodule